// File: doc/BRIEF.md
# Pipeline PC Select and Hazard Control

This block picks the fetch address and drives the stall and bubble controls for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) of a small 64-bit teaching ISA. It sees the instruction class and a few fields that sit in each pipeline register. From these it derives the program counter that fetch uses in the current cycle. It also keeps the predicted next PC in its own register, which sits in front of fetch. The ALU, register file, data memory and instruction decoder are outside the block. They supply the fields that the block reads and obey the controls that it drives.

Every jump and every call is predicted taken. A conditional jump whose condition fails is found one stage late, when it sits in the memory-stage register. The block then refetches from the jump's fall-through address and squashes the two younger instructions that were fetched on the wrong path. A return instruction holds fetch until its popped return address arrives from writeback. A load that feeds the instruction right behind it costs one interlock cycle. The pipeline registers hold when stalled and take a no-op when bubbled. All controls are combinational functions of the pipeline-register contents of the current cycle. The only state is the predicted-PC register.

Instruction class codes (4 bits): 0 halt, 1 nop, 2 register move, 3 immediate move, 4 store, 5 load, 6 ALU op, 7 jump, 8 call, 9 return, 10 push, 11 pop. A jump with function code 0 is unconditional. Register id 15 means "no register".

Top module: `pipe_flow_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the predicted-PC register holds RESET_PC. With no hazard present, fetch_pc equals pred_pc.
- R2: At each clock edge where stall_f is low, pred_pc loads f_valc if f_icode is 7 (jump) or 8 (call), and f_valp for any other f_icode.
- R3: When there is no misprediction and no return in writeback, fetch_pc equals pred_pc.
- R4: A misprediction holds when m_icode is 7, m_ifun is not 0 and m_cnd is 0. While it holds, fetch_pc equals m_valp, bubble_d and bubble_e are 1, and stall_f and stall_d are 0.
- R5: A jump in memory with m_ifun equal to 0, and a call in memory (m_icode 8), never start recovery, whatever the value of m_cnd.
- R6: While a return (icode 9) sits in decode, execute or memory, and there is neither a misprediction nor a load-use hazard, stall_f and bubble_d are 1 and stall_d and bubble_e are 0.
- R7: When w_icode is 9 and there is no misprediction, fetch_pc equals w_valm.
- R8: A load-use hazard holds when e_icode is 5 or 11, e_dstm is not 15, and e_dstm equals d_srca or d_srcb. Without a misprediction it gives stall_f, stall_d and bubble_e equal to 1 and bubble_d equal to 0, even when a return is also in flight.
- R9: A misprediction takes priority over every other hazard. Fetch is never stalled during recovery.
- R10: stall_d and bubble_d are never both 1. pred_pc does not change across an edge at which stall_f is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_icode | input | 4 | Class of the instruction fetched at fetch_pc |
| f_valc | input | AW | Constant field of the fetched instruction |
| f_valp | input | AW | Fall-through address of the fetched instruction |
| d_icode | input | 4 | Class in the decode register |
| d_srca | input | RW | First source register in decode |
| d_srcb | input | RW | Second source register in decode |
| e_icode | input | 4 | Class in the execute register |
| e_dstm | input | RW | Memory-result destination in execute |
| m_icode | input | 4 | Class in the memory register |
| m_ifun | input | 4 | Function code in the memory register |
| m_cnd | input | 1 | Stored condition result in the memory register |
| m_valp | input | AW | Fall-through address saved with the memory-stage instruction |
| w_icode | input | 4 | Class in the writeback register |
| w_valm | input | AW | Value read from memory, in writeback |
| fetch_pc | output | AW | Address to fetch this cycle |
| pred_pc | output | AW | Predicted-PC register |
| stall_f | output | 1 | Hold the predicted-PC register |
| stall_d | output | 1 | Hold the decode register |
| bubble_d | output | 1 | Load a no-op into the decode register |
| bubble_e | output | 1 | Load a no-op into the execute register |

## Verification
The controls are combinational, so a wrong priority or a wrong hazard term is visible at the stall and bubble pins in the same cycle as the stimulus. The only internal state is the predicted-PC register. A wrong load, or a missed hold, shows up on pred_pc one edge later. It also shows on fetch_pc in that cycle, unless recovery or a return overrides it. The bench runs a reference model of the prediction register next to the design. It compares all six outputs every cycle under random pipeline contents that are biased toward register collisions and control instructions. Directed cycles cover the priority corners and the unconditional-jump and call exemptions.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [3:0] {
    IC_HALT  = 4'd0,
    IC_NOP   = 4'd1,
    IC_RRMOV = 4'd2,
    IC_IRMOV = 4'd3,
    IC_STORE = 4'd4,
    IC_LOAD  = 4'd5,
    IC_ALU   = 4'd6,
    IC_JUMP  = 4'd7,
    IC_CALL  = 4'd8,
    IC_RET   = 4'd9,
    IC_PUSH  = 4'd10,
    IC_POP   = 4'd11
  } icode_e;

  localparam logic [3:0] FN_ALWAYS = 4'd0;

  function automatic logic is_class(input logic [3:0] code, input icode_e cls);
    return code == 4'(cls);
  endfunction
endpackage

// File: rtl/pfc_hazard.sv
module pfc_hazard
  import pfc_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic [3:0]    d_icode,
  input  logic [3:0]    e_icode,
  input  logic [3:0]    m_icode,
  input  logic [3:0]    w_icode,
  input  logic [3:0]    m_ifun,
  input  logic          m_cnd,
  input  logic [RW-1:0] d_srca,
  input  logic [RW-1:0] d_srcb,
  input  logic [RW-1:0] e_dstm,
  output logic          mispredict,
  output logic          ret_busy,
  output logic          ret_at_wb,
  output logic          load_use
);
  localparam logic [RW-1:0] REG_NONE = '1;

  logic e_is_load;
  logic dst_hit;

  always_comb begin
    mispredict = is_class(m_icode, IC_JUMP) && (m_ifun != FN_ALWAYS) && !m_cnd;
    ret_busy   = is_class(d_icode, IC_RET) || is_class(e_icode, IC_RET) ||
                 is_class(m_icode, IC_RET);
    ret_at_wb  = is_class(w_icode, IC_RET);
    e_is_load  = is_class(e_icode, IC_LOAD) || is_class(e_icode, IC_POP);
    dst_hit    = (e_dstm != REG_NONE) && ((e_dstm == d_srca) || (e_dstm == d_srcb));
    load_use   = e_is_load && dst_hit;
  end
endmodule

// File: rtl/pfc_stage_ctl.sv
module pfc_stage_ctl (
  input  logic mispredict,
  input  logic ret_busy,
  input  logic load_use,
  output logic stall_f,
  output logic stall_d,
  output logic bubble_d,
  output logic bubble_e
);
  typedef enum logic [1:0] {CASE_NONE, CASE_RET, CASE_LOADUSE, CASE_RECOVER} hz_case_e;

  hz_case_e hz;

  always_comb begin
    if (mispredict)    hz = CASE_RECOVER;
    else if (load_use) hz = CASE_LOADUSE;
    else if (ret_busy) hz = CASE_RET;
    else               hz = CASE_NONE;
  end

  always_comb begin
    stall_f  = 1'b0;
    stall_d  = 1'b0;
    bubble_d = 1'b0;
    bubble_e = 1'b0;
    unique case (hz)
      CASE_RECOVER: begin
        bubble_d = 1'b1;
        bubble_e = 1'b1;
      end
      CASE_LOADUSE: begin
        stall_f  = 1'b1;
        stall_d  = 1'b1;
        bubble_e = 1'b1;
      end
      CASE_RET: begin
        stall_f  = 1'b1;
        bubble_d = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pfc_pc_sel.sv
module pfc_pc_sel
  import pfc_pkg::*;
#(
  parameter int           AW       = 64,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mispredict,
  input  logic          ret_at_wb,
  input  logic          stall_f,
  input  logic [AW-1:0] m_valp,
  input  logic [AW-1:0] w_valm,
  input  logic [3:0]    f_icode,
  input  logic [AW-1:0] f_valc,
  input  logic [AW-1:0] f_valp,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] pred_pc
);
  logic          take_const;
  logic [AW-1:0] next_pred;

  always_comb begin
    if (mispredict)     fetch_pc = m_valp;
    else if (ret_at_wb) fetch_pc = w_valm;
    else                fetch_pc = pred_pc;
  end

  always_comb begin
    take_const = is_class(f_icode, IC_JUMP) || is_class(f_icode, IC_CALL);
    next_pred  = take_const ? f_valc : f_valp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pred_pc <= RESET_PC;
    else if (!stall_f) pred_pc <= next_pred;
  end
endmodule

// File: rtl/pipe_flow_ctl.sv
module pipe_flow_ctl #(
  parameter int            AW       = 64,
  parameter int            RW       = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    f_icode,
  input  logic [AW-1:0] f_valc,
  input  logic [AW-1:0] f_valp,
  input  logic [3:0]    d_icode,
  input  logic [RW-1:0] d_srca,
  input  logic [RW-1:0] d_srcb,
  input  logic [3:0]    e_icode,
  input  logic [RW-1:0] e_dstm,
  input  logic [3:0]    m_icode,
  input  logic [3:0]    m_ifun,
  input  logic          m_cnd,
  input  logic [AW-1:0] m_valp,
  input  logic [3:0]    w_icode,
  input  logic [AW-1:0] w_valm,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] pred_pc,
  output logic          stall_f,
  output logic          stall_d,
  output logic          bubble_d,
  output logic          bubble_e
);
  logic mispredict;
  logic ret_busy;
  logic ret_at_wb;
  logic load_use;

  pfc_hazard #(.RW(RW)) u_hazard (
    .d_icode    (d_icode),
    .e_icode    (e_icode),
    .m_icode    (m_icode),
    .w_icode    (w_icode),
    .m_ifun     (m_ifun),
    .m_cnd      (m_cnd),
    .d_srca     (d_srca),
    .d_srcb     (d_srcb),
    .e_dstm     (e_dstm),
    .mispredict (mispredict),
    .ret_busy   (ret_busy),
    .ret_at_wb  (ret_at_wb),
    .load_use   (load_use)
  );

  pfc_stage_ctl u_stage (
    .mispredict (mispredict),
    .ret_busy   (ret_busy),
    .load_use   (load_use),
    .stall_f    (stall_f),
    .stall_d    (stall_d),
    .bubble_d   (bubble_d),
    .bubble_e   (bubble_e)
  );

  pfc_pc_sel #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .mispredict (mispredict),
    .ret_at_wb  (ret_at_wb),
    .stall_f    (stall_f),
    .m_valp     (m_valp),
    .w_valm     (w_valm),
    .f_icode    (f_icode),
    .f_valc     (f_valc),
    .f_valp     (f_valp),
    .fetch_pc   (fetch_pc),
    .pred_pc    (pred_pc)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int AW = 64,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    f_icode,
  input logic [AW-1:0] f_valc,
  input logic [AW-1:0] f_valp,
  input logic [3:0]    d_icode,
  input logic [RW-1:0] d_srca,
  input logic [RW-1:0] d_srcb,
  input logic [3:0]    e_icode,
  input logic [RW-1:0] e_dstm,
  input logic [3:0]    m_icode,
  input logic [3:0]    m_ifun,
  input logic          m_cnd,
  input logic [AW-1:0] m_valp,
  input logic [3:0]    w_icode,
  input logic [AW-1:0] w_valm,
  input logic [AW-1:0] fetch_pc,
  input logic [AW-1:0] pred_pc,
  input logic          stall_f,
  input logic          stall_d,
  input logic          bubble_d,
  input logic          bubble_e
);
  logic mis_seen;
  logic ret_seen;
  logic lu_seen;
  logic was_reset;

  assign mis_seen = (m_icode == 4'd7) && (m_ifun != 4'd0) && !m_cnd;
  assign ret_seen = (d_icode == 4'd9) || (e_icode == 4'd9) || (m_icode == 4'd9);
  assign lu_seen  = ((e_icode == 4'd5) || (e_icode == 4'd11)) && (e_dstm != '1) &&
                    ((e_dstm == d_srca) || (e_dstm == d_srcb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_reset <= 1'b0;
    else        was_reset <= 1'b1;
  end

  a_r2_pred_load: assert property (@(posedge clk) disable iff (!rst_n)
    (was_reset && !stall_f) |=>
      pred_pc == (($past(f_icode) == 4'd7 || $past(f_icode) == 4'd8) ? $past(f_valc) : $past(f_valp)));

  a_r4_recover: assert property (@(posedge clk) disable iff (!rst_n)
    mis_seen |-> (fetch_pc == m_valp && bubble_d && bubble_e && !stall_f && !stall_d));

  a_r5_no_false_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (!mis_seen && !ret_seen && !lu_seen) |-> (!bubble_d && !bubble_e && !stall_f && !stall_d));

  a_r6_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_seen && !mis_seen && !lu_seen) |-> (stall_f && bubble_d && !stall_d && !bubble_e));

  a_r7_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icode == 4'd9 && !mis_seen) |-> fetch_pc == w_valm);

  a_r8_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_seen && !mis_seen) |-> (stall_f && stall_d && bubble_e && !bubble_d));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_d && bubble_d));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (was_reset && stall_f) |=> $stable(pred_pc));
endmodule

bind pipe_flow_ctl pfc_checker #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/tb_pipe_flow_ctl.sv
module tb_pipe_flow_ctl;
  localparam int AW = 64;
  localparam int RW = 4;
  localparam logic [AW-1:0] RST_PC = 64'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    f_icode = 4'd1, d_icode = 4'd1, e_icode = 4'd1, m_icode = 4'd1, w_icode = 4'd1;
  logic [3:0]    m_ifun = 4'd0;
  logic          m_cnd = 1'b1;
  logic [AW-1:0] f_valc = '0, f_valp = '0, m_valp = '0, w_valm = '0;
  logic [RW-1:0] d_srca = '1, d_srcb = '1, e_dstm = '1;
  logic [AW-1:0] fetch_pc, pred_pc;
  logic          stall_f, stall_d, bubble_d, bubble_e;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [AW-1:0] exp_pred = RST_PC;

  always #4 clk = ~clk;

  pipe_flow_ctl #(.AW(AW), .RW(RW), .RESET_PC(RST_PC)) dut (.*);

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic idle();
    f_icode = 4'd1; d_icode = 4'd1; e_icode = 4'd1; m_icode = 4'd1; w_icode = 4'd1;
    m_ifun = 4'd0; m_cnd = 1'b1;
    d_srca = '1; d_srcb = '1; e_dstm = '1;
    f_valc = {$urandom, $urandom}; f_valp = {$urandom, $urandom};
    m_valp = {$urandom, $urandom}; w_valm = {$urandom, $urandom};
  endtask

  function automatic logic [RW-1:0] rnd_reg();
    int r = $urandom % 5;
    return (r == 4) ? '1 : RW'(r);
  endfunction

  // one cycle: sample at negedge against the model, then advance it at posedge
  task automatic step(input string tag);
    logic mis, ret, lu, retw;
    logic [3:0] ctl, exp_ctl;
    logic [AW-1:0] exp_fpc, nxt;
    string t;
    @(negedge clk);
    mis  = (m_icode == 4'd7) && (m_ifun != 4'd0) && !m_cnd;
    ret  = (d_icode == 4'd9) || (e_icode == 4'd9) || (m_icode == 4'd9);
    retw = (w_icode == 4'd9);
    lu   = (e_icode == 4'd5 || e_icode == 4'd11) && (e_dstm != '1) &&
           (e_dstm == d_srca || e_dstm == d_srcb);
    if (mis)      exp_ctl = 4'b0011;
    else if (lu)  exp_ctl = 4'b1101;
    else if (ret) exp_ctl = 4'b1010;
    else          exp_ctl = 4'b0000;
    exp_fpc = mis ? m_valp : (retw ? w_valm : exp_pred);
    t = tag;
    if (t == "") t = mis ? "R4 R9" : (lu ? "R8" : (ret ? "R6" : (retw ? "R7" : "R3 R5")));
    ctl = {stall_f, stall_d, bubble_d, bubble_e};
    check({t, " controls"}, AW'(ctl), AW'(exp_ctl));
    check({t, " fetch_pc"}, fetch_pc, exp_fpc);
    check("R10 no stall+bubble in decode", AW'(stall_d & bubble_d), '0);
    nxt = exp_ctl[3] ? exp_pred : ((f_icode == 4'd7 || f_icode == 4'd8) ? f_valc : f_valp);
    @(posedge clk);
    exp_pred = nxt;
    #1;
    check(exp_ctl[3] ? "R10 pred held" : "R2 pred loaded", pred_pc, exp_pred);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R1 pred_pc in reset", pred_pc, RST_PC);
    rst_n = 1'b1;
    check("R1 fetch_pc after reset", fetch_pc, RST_PC);

    // R2: jump predicted taken, call predicted taken, other uses valP
    idle(); f_icode = 4'd7; step("R2 jump");
    idle(); f_icode = 4'd8; step("R2 call");
    idle(); f_icode = 4'd6; step("R2 alu");

    // R4: conditional jump failed in memory
    idle(); m_icode = 4'd7; m_ifun = 4'd3; m_cnd = 1'b0; step("R4 mispredict");
    // R5: conditional taken, unconditional with cnd 0, call with cnd 0
    idle(); m_icode = 4'd7; m_ifun = 4'd3; m_cnd = 1'b1; step("R5 cond taken");
    idle(); m_icode = 4'd7; m_ifun = 4'd0; m_cnd = 1'b0; step("R5 jmp cnd0");
    idle(); m_icode = 4'd8; m_ifun = 4'd0; m_cnd = 1'b0; step("R5 call cnd0");

    // R6: return walking decode, execute, memory; R7: then writeback
    idle(); d_icode = 4'd9; f_icode = 4'd7; step("R6 ret in D");
    idle(); e_icode = 4'd9; step("R6 ret in E");
    idle(); m_icode = 4'd9; step("R6 ret in M");
    idle(); w_icode = 4'd9; f_icode = 4'd3; step("R7 ret in W");

    // R8: load-use on srcA, on srcB, pop, and no hazard when dst is none
    idle(); e_icode = 4'd5; e_dstm = 4'd2; d_srca = 4'd2; step("R8 load srcA");
    idle(); e_icode = 4'd11; e_dstm = 4'd0; d_srcb = 4'd0; step("R8 pop srcB");
    idle(); e_icode = 4'd5; e_dstm = '1; d_srca = '1; step("R8 none reg");
    idle(); e_icode = 4'd4; e_dstm = 4'd2; d_srca = 4'd2; step("R8 store no hazard");
    idle(); e_icode = 4'd5; e_dstm = 4'd1; d_srca = 4'd1; d_icode = 4'd9; step("R8 over ret");

    // R9: recovery beats return and load-use
    idle(); m_icode = 4'd7; m_ifun = 4'd1; m_cnd = 1'b0; d_icode = 4'd9;
    e_icode = 4'd5; e_dstm = 4'd3; d_srca = 4'd3; step("R9 recover over all");
    idle(); m_icode = 4'd7; m_ifun = 4'd2; m_cnd = 1'b0; w_icode = 4'd9; step("R9 recover over ret W");

    // random mix
    for (int i = 0; i < 600; i++) begin
      idle();
      f_icode = 4'($urandom % 12);
      d_icode = 4'($urandom % 12);
      e_icode = 4'($urandom % 12);
      m_icode = 4'($urandom % 12);
      w_icode = 4'($urandom % 12);
      m_ifun  = 4'($urandom % 3);
      m_cnd   = 1'($urandom);
      d_srca  = rnd_reg();
      d_srcb  = rnd_reg();
      e_dstm  = rnd_reg();
      step("");
    end
    finish_up();
  end
endmodule